// File: doc/BRIEF.md
# Multi-Mode Pointer Update Unit

This block advances an address pointer for a signal-processing datapath. It holds a small bank of slots. Each slot has three registers: a pointer, an offset and a modifier. For the selected slot the block computes the next pointer from three things: the current pointer, an offset chosen by the caller, and the slot's modifier. The modifier value chooses one of three kinds of arithmetic:

- Linear arithmetic: plain two's-complement addition.
- Reverse-carry addition: used to produce the bit-scrambled data order of a fast Fourier transform.
- Modulo addition: keeps the pointer inside a circular buffer. The buffer boundaries are derived from the pointer itself.

Results are combinational from the selected slot and the control inputs. A single update strobe writes the new pointer back into the selected slot on the next rising clock edge. The effective-address output returns one of two values. In post-update form it returns the old pointer. In pre-update form it returns the computed pointer.

Every pin is a plain control or data pin. There is no stream handshake, because the block accepts a load or an update on every cycle and never applies back-pressure. Slot contents are set through a load port. Instruction decode and memory access are left to the surrounding datapath.

Top module: `agu_top`

## Requirements
- R1: After reset every slot holds pointer 0, offset 0 and modifier all-ones, which is linear mode.
- R2: The `ofs_sel` code picks the offset as follows. Code 0 is the slot's offset register. Code 1 is +1. Code 2 is -1. Code 3 is `disp` sign-extended from DISP_W bits to AW bits.
- R3: With modifier all-ones, `next_o` equals the pointer plus the offset, modulo 2^AW.
- R4: With modifier 0, `next_o` equals the bit-reverse of the sum of the bit-reversed pointer and the bit-reversed offset. The sum wraps, and the offset is treated as unsigned.
- R5: In reverse-carry mode, with offset 512 and repeated updates from pointer 0, the pointer runs 0, 512, 256, 768, 128, 640.
- R6: A modifier value v from 1 to 2^MOD_W-1 selects modulo mode with buffer size v+1. The base is the pointer with its k low bits cleared, where k is the smallest value with 2^k >= v+1. A raw sum above base+v has v+1 subtracted. A raw sum below the base has v+1 added. Offsets of magnitude up to v+1 are supported.
- R7: With a buffer size of 24, pointer 55 plus 1 gives 32, and pointer 32 minus 1 gives 55.
- R8: A modifier value that is neither all-ones nor in the range 0 to 2^MOD_W-1 selects linear mode.
- R9: An update strobe writes `next_o` into the selected slot's pointer only. All other slots, and the slot's offset and modifier registers, are unchanged.
- R10: `ea_o` equals the current pointer when `pre_mode` is 0, and equals `next_o` when `pre_mode` is 1.
- R11: A load writes `ld_data` into slot `ld_idx` on the next edge. `ld_kind` 0 selects the pointer, 1 the offset and 2 the modifier. A pointer load beats an update to the same slot in the same cycle.
- R12: In modulo mode, pointer bits at and above bit MOD_W pass through an update unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe |
| ld_kind | input | 2 | Target register of the load (0 pointer, 1 offset, 2 modifier) |
| ld_idx | input | IDX_W | Slot written by the load |
| ld_data | input | AW | Load value |
| upd_en | input | 1 | Update strobe for the selected slot |
| sel_idx | input | IDX_W | Selected slot |
| ofs_sel | input | 2 | Offset source code |
| disp | input | DISP_W | Signed displacement |
| pre_mode | input | 1 | 1 selects the pre-update effective address |
| ptr_o | output | AW | Current pointer of the selected slot |
| next_o | output | AW | Computed next pointer |
| ea_o | output | AW | Effective address |

## Verification
The assertions check the following properties on every cycle:
- An update lands in the pointer of the selected slot.
- A pointer load lands in its slot.
- Linear increment adds exactly one.
- Reverse-carry addition of a zero displacement leaves the pointer unchanged.
- Modulo mode never changes the pointer bits above the buffer field.

The bench's scenarios cover what the assertions cannot:
- The exact wrap points of modulo buffers of several sizes.
- Reverse-carry results for chosen operands, including the scrambled FFT sequence.
- The reset contents of every slot.
- Isolation between slots.
- Load-over-update priority.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;
  localparam logic [1:0] OFS_NREG = 2'd0;
  localparam logic [1:0] OFS_INC  = 2'd1;
  localparam logic [1:0] OFS_DEC  = 2'd2;
  localparam logic [1:0] OFS_DISP = 2'd3;

  localparam logic [1:0] LD_PTR = 2'd0;
  localparam logic [1:0] LD_OFS = 2'd1;
  localparam logic [1:0] LD_MOD = 2'd2;

  typedef enum logic [1:0] {
    MODE_LIN = 2'd0,
    MODE_REV = 2'd1,
    MODE_CIRC = 2'd2
  } arith_mode_e;
endpackage

// File: rtl/agu_regbank.sv
`timescale 1ns/1ps
module agu_regbank #(
  parameter int AW    = 32,
  parameter int NREG  = 4,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [1:0]       ld_kind,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [AW-1:0]    ld_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [AW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [AW-1:0]    rd_ptr,
  output logic [AW-1:0]    rd_ofs,
  output logic [AW-1:0]    rd_mod
);
  import agu_pkg::*;

  logic [AW-1:0] ptr_q [NREG];
  logic [AW-1:0] ofs_q [NREG];
  logic [AW-1:0] mod_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        ptr_q[i] <= '0;
        ofs_q[i] <= '0;
        mod_q[i] <= '1;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (ld_en && ld_idx == IDX_W'(i)) begin
          case (ld_kind)
            LD_PTR:  ptr_q[i] <= ld_data;
            LD_OFS:  ofs_q[i] <= ld_data;
            LD_MOD:  mod_q[i] <= ld_data;
            default: ;
          endcase
        end
        // a pointer load in the same cycle takes priority
        if (wr_en && wr_idx == IDX_W'(i) &&
            !(ld_en && ld_kind == LD_PTR && ld_idx == IDX_W'(i)))
          ptr_q[i] <= wr_data;
      end
    end
  end

  assign rd_ptr = ptr_q[rd_idx];
  assign rd_ofs = ofs_q[rd_idx];
  assign rd_mod = mod_q[rd_idx];
endmodule

// File: rtl/agu_revadd.sv
`timescale 1ns/1ps
module agu_revadd #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic [AW-1:0] sum
);
  logic [AW-1:0] a_rev, b_rev, s_rev;

  for (genvar g = 0; g < AW; g++) begin : g_flip
    assign a_rev[g] = a[AW-1-g];
    assign b_rev[g] = b[AW-1-g];
    assign sum[g]   = s_rev[AW-1-g];
  end

  // carry now ripples from the top bit of the original order downward
  assign s_rev = a_rev + b_rev;
endmodule

// File: rtl/agu_modadd.sv
`timescale 1ns/1ps
module agu_modadd #(
  parameter int AW    = 32,
  parameter int MOD_W = 24,
  localparam int XW   = AW + 2
) (
  input  logic [AW-1:0]    ptr,
  input  logic [AW-1:0]    ofs,
  input  logic [MOD_W-1:0] size_m1,
  output logic [AW-1:0]    res
);
  logic [MOD_W-1:0]     mask;
  logic [AW-1:0]        mask_ext;
  logic [AW-1:0]        base;
  logic signed [XW-1:0] rel;
  logic signed [XW-1:0] top_x;
  logic signed [XW-1:0] size_x;
  logic signed [XW-1:0] rel_fix;

  // smear the highest set bit downward: mask = 2^k - 1
  always_comb begin
    mask = size_m1;
    for (int s = 1; s < MOD_W; s = s * 2)
      mask = mask | (mask >> s);
  end

  assign mask_ext = AW'(mask);
  assign base     = ptr & ~mask_ext;
  assign top_x    = XW'(size_m1);
  assign size_x   = XW'(size_m1) + XW'(1);
  assign rel      = $signed({2'b00, ptr & mask_ext}) +
                    $signed({{2{ofs[AW-1]}}, ofs});

  always_comb begin
    if (rel > top_x)
      rel_fix = rel - size_x;
    else if (rel < 0)
      rel_fix = rel + size_x;
    else
      rel_fix = rel;
  end

  assign res = base + rel_fix[AW-1:0];
endmodule

// File: rtl/agu_core.sv
`timescale 1ns/1ps
module agu_core #(
  parameter int AW     = 32,
  parameter int DISP_W = 16,
  parameter int MOD_W  = 24
) (
  input  logic [AW-1:0]     ptr,
  input  logic [AW-1:0]     ofs_reg,
  input  logic [AW-1:0]     mod_reg,
  input  logic [1:0]        ofs_sel,
  input  logic [DISP_W-1:0] disp,
  output logic [AW-1:0]     next
);
  import agu_pkg::*;

  arith_mode_e   mode;
  logic [AW-1:0] ofs;
  logic [AW-1:0] lin_sum, rev_sum, circ_sum;

  always_comb begin
    case (ofs_sel)
      OFS_NREG: ofs = ofs_reg;
      OFS_INC:  ofs = AW'(1);
      OFS_DEC:  ofs = '1;
      default:  ofs = {{(AW-DISP_W){disp[DISP_W-1]}}, disp};
    endcase
  end

  always_comb begin
    if (&mod_reg)
      mode = MODE_LIN;
    else if (mod_reg == '0)
      mode = MODE_REV;
    else if (mod_reg[AW-1:MOD_W] == '0)
      mode = MODE_CIRC;
    else
      mode = MODE_LIN;
  end

  assign lin_sum = ptr + ofs;

  agu_revadd #(.AW(AW)) u_rev (
    .a   (ptr),
    .b   (ofs),
    .sum (rev_sum)
  );

  agu_modadd #(.AW(AW), .MOD_W(MOD_W)) u_circ (
    .ptr     (ptr),
    .ofs     (ofs),
    .size_m1 (mod_reg[MOD_W-1:0]),
    .res     (circ_sum)
  );

  always_comb begin
    case (mode)
      MODE_REV:  next = rev_sum;
      MODE_CIRC: next = circ_sum;
      default:   next = lin_sum;
    endcase
  end
endmodule

// File: rtl/agu_top.sv
`timescale 1ns/1ps
module agu_top #(
  parameter int AW     = 32,
  parameter int NREG   = 4,
  parameter int DISP_W = 16,
  parameter int MOD_W  = 24,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [1:0]        ld_kind,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [AW-1:0]     ld_data,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic [1:0]        ofs_sel,
  input  logic [DISP_W-1:0] disp,
  input  logic              pre_mode,
  output logic [AW-1:0]     ptr_o,
  output logic [AW-1:0]     next_o,
  output logic [AW-1:0]     ea_o
);
  logic [AW-1:0] ptr_cur, ofs_cur, mod_cur, next_val;

  agu_regbank #(.AW(AW), .NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_kind (ld_kind),
    .ld_idx  (ld_idx),
    .ld_data (ld_data),
    .wr_en   (upd_en),
    .wr_idx  (sel_idx),
    .wr_data (next_val),
    .rd_idx  (sel_idx),
    .rd_ptr  (ptr_cur),
    .rd_ofs  (ofs_cur),
    .rd_mod  (mod_cur)
  );

  agu_core #(.AW(AW), .DISP_W(DISP_W), .MOD_W(MOD_W)) u_core (
    .ptr     (ptr_cur),
    .ofs_reg (ofs_cur),
    .mod_reg (mod_cur),
    .ofs_sel (ofs_sel),
    .disp    (disp),
    .next    (next_val)
  );

  assign ptr_o  = ptr_cur;
  assign next_o = next_val;
  assign ea_o   = pre_mode ? next_val : ptr_cur;
endmodule

// File: rtl/agu_chk.sv
`timescale 1ns/1ps
module agu_chk #(
  parameter int AW     = 32,
  parameter int DISP_W = 16,
  parameter int MOD_W  = 24,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_en,
  input logic [1:0]        ld_kind,
  input logic [IDX_W-1:0]  ld_idx,
  input logic [AW-1:0]     ld_data,
  input logic              upd_en,
  input logic [IDX_W-1:0]  sel_idx,
  input logic [1:0]        ofs_sel,
  input logic [DISP_W-1:0] disp,
  input logic [AW-1:0]     ptr_o,
  input logic [AW-1:0]     next_o,
  input logic [AW-1:0]     mod_cur
);
  logic circ_mode;
  assign circ_mode = (mod_cur != '0) && (mod_cur[AW-1:MOD_W] == '0);

  // R1: first cycle out of reset shows a cleared pointer
  p_reset_ptr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> ptr_o == '0);

  // R9: an update without a load lands in the selected pointer
  p_update_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !ld_en) |=> (sel_idx != $past(sel_idx)) || (ptr_o == $past(next_o)));

  // R11: a pointer load is visible in its slot one edge later
  p_ptr_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_kind == 2'd0) |=> (sel_idx != $past(ld_idx)) || (ptr_o == $past(ld_data)));

  // R3: linear increment
  p_linear_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&mod_cur && ofs_sel == 2'd1) |-> next_o == ptr_o + AW'(1));

  // R4: reverse-carry with a zero displacement leaves the pointer alone
  p_rev_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_cur == '0 && ofs_sel == 2'd3 && disp == '0) |-> next_o == ptr_o);

  // R12: high pointer bits survive modulo arithmetic
  p_circ_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    circ_mode |-> next_o[AW-1:MOD_W] == ptr_o[AW-1:MOD_W]);
endmodule

bind agu_top agu_chk #(
  .AW(AW), .DISP_W(DISP_W), .MOD_W(MOD_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_kind(ld_kind),
  .ld_idx(ld_idx), .ld_data(ld_data), .upd_en(upd_en),
  .sel_idx(sel_idx), .ofs_sel(ofs_sel), .disp(disp),
  .ptr_o(ptr_o), .next_o(next_o), .mod_cur(mod_cur)
);

// File: tb/agu_top_tb_top.sv
`timescale 1ns/1ps
module agu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_kind = '0;
  logic [1:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic        upd_en = 1'b0;
  logic [1:0]  sel_idx = '0;
  logic [1:0]  ofs_sel = '0;
  logic [15:0] disp = '0;
  logic        pre_mode = 1'b0;
  logic [31:0] ptr_o, next_o, ea_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  agu_top dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_kind(ld_kind),
    .ld_idx(ld_idx), .ld_data(ld_data), .upd_en(upd_en),
    .sel_idx(sel_idx), .ofs_sel(ofs_sel), .disp(disp),
    .pre_mode(pre_mode), .ptr_o(ptr_o), .next_o(next_o), .ea_o(ea_o)
  );

  typedef struct packed {
    logic [31:0] m;
    logic [31:0] r;
    logic [31:0] n;
    logic [15:0] d;
    logic [1:0]  sel;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{32'hFFFF_FFFF, 32'h10,        32'h20,        16'h0,    2'd0, 32'h30},        // R3 R2
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,         16'h0,    2'd1, 32'h0},         // R3 wrap
    '{32'hFFFF_FFFF, 32'h0,         32'h0,         16'h0,    2'd2, 32'hFFFF_FFFF}, // R3 R2
    '{32'hFFFF_FFFF, 32'h100,       32'h0,         16'hFFF0, 2'd3, 32'hF0},        // R2 disp
    '{32'hFFFF_FFFF, 32'h5,         32'hFFFF_FFFE, 16'h0,    2'd0, 32'h3},         // R3 signed
    '{32'h0,         32'h1,         32'h0,         16'h0,    2'd1, 32'h0},         // R4
    '{32'h0,         32'h8000_0000, 32'h8000_0000, 16'h0,    2'd0, 32'h4000_0000}, // R4
    '{32'h0,         32'h300,       32'h200,       16'h0,    2'd0, 32'h80},        // R4
    '{32'h0,         32'h0,         32'hFFFF_FFFF, 16'h0,    2'd0, 32'hFFFF_FFFF}, // R4 unsigned
    '{32'd23,        32'd55,        32'h0,         16'h0,    2'd1, 32'd32},        // R7
    '{32'd23,        32'd32,        32'h0,         16'h0,    2'd2, 32'd55},        // R7
    '{32'd23,        32'd40,        32'd5,         16'h0,    2'd0, 32'd45},        // R6
    '{32'd23,        32'd50,        32'd10,        16'h0,    2'd0, 32'd36},        // R6 above
    '{32'd23,        32'd34,        32'h0,         16'hFFFB, 2'd3, 32'd53},        // R6 below
    '{32'd23,        32'd40,        32'd24,        16'h0,    2'd0, 32'd40},        // R6 full M
    '{32'd1,         32'h1001,      32'h0,         16'h0,    2'd1, 32'h1000},      // R6 M=2
    '{32'h00FF_FFFF, 32'h12FF_FFFF, 32'h0,         16'h0,    2'd1, 32'h1200_0000}, // R12
    '{32'h0100_0000, 32'h12FF_FFFF, 32'h0,         16'h0,    2'd1, 32'h1300_0000}  // R8
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] kind, input logic [1:0] idx, input logic [31:0] val);
    ld_en = 1'b1; ld_kind = kind; ld_idx = idx; ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [31:0] SEQ [6] = '{32'd0, 32'd512, 32'd256, 32'd768, 32'd128, 32'd640};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents of every slot
    for (int i = 0; i < 4; i++) begin
      sel_idx = 2'(i); ofs_sel = 2'd0; #1;
      chk("R1 ptr", ptr_o, 32'h0);
      chk("R1 ofs zero", next_o, 32'h0);
      ofs_sel = 2'd1; #1;
      chk("R1 linear", next_o, 32'h1);
    end
    @(negedge clk);

    // table walk on slot 0
    sel_idx = 2'd0;
    for (int v = 0; v < NV; v++) begin
      load(2'd2, 2'd0, TBL[v].m);
      load(2'd0, 2'd0, TBL[v].r);
      load(2'd1, 2'd0, TBL[v].n);
      ofs_sel = TBL[v].sel; disp = TBL[v].d; #1;
      chk($sformatf("R2-R12 vec %0d", v), next_o, TBL[v].exp);
    end
    disp = '0;

    // R5: scrambled sequence
    load(2'd2, 2'd0, 32'h0);
    load(2'd0, 2'd0, 32'h0);
    load(2'd1, 2'd0, 32'd512);
    ofs_sel = 2'd0; upd_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #1 chk("R5 seq", ptr_o, SEQ[i]);
      @(negedge clk);
    end
    upd_en = 1'b0;

    // R9: isolation between slots
    load(2'd0, 2'd1, 32'h111);
    load(2'd0, 2'd2, 32'h222);
    sel_idx = 2'd1; ofs_sel = 2'd1; upd_en = 1'b1;
    @(negedge clk);
    upd_en = 1'b0; #1;
    chk("R9 target", ptr_o, 32'h112);
    sel_idx = 2'd2; #1;
    chk("R9 neighbour", ptr_o, 32'h222);
    sel_idx = 2'd1; ofs_sel = 2'd0; #1;
    chk("R9 offset untouched", next_o, 32'h112);

    // R10: effective address forms
    ofs_sel = 2'd1; pre_mode = 1'b0; #1;
    chk("R10 post", ea_o, 32'h112);
    pre_mode = 1'b1; #1;
    chk("R10 pre", ea_o, 32'h113);
    pre_mode = 1'b0;
    @(negedge clk);

    // R11: load beats update on the same slot
    upd_en = 1'b1;
    load(2'd0, 2'd1, 32'h500);
    upd_en = 1'b0; #1;
    chk("R11 priority", ptr_o, 32'h500);
    load(2'd1, 2'd1, 32'h30);
    ofs_sel = 2'd0; #1;
    chk("R11 offset load", next_o, 32'h530);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule